// File: doc/BRIEF.md
# Weighted Round-Robin Bus Arbiter

This block decides which of up to eight masters owns a shared 8-bit internal bus for the next byte transfer. Every master raises a request line and waits for its grant line. A small credit counter per master, refilled from that master's weight input, limits how many bytes it may move in one arbitration round. A rotating pointer decides who is searched first. Together they give each master a share of bus time in proportion to its weight, and every requesting master with a nonzero weight is served at least once per round.

The control is a three-state machine. **ST_IDLE** looks for a winner. The transition *IDLE→BUSY* is taken when a requesting master with nonzero weight still holds credit. The transition *IDLE→RELOAD* is taken when masters with nonzero weight are requesting but none of them has credit left. *IDLE→IDLE* is taken when nothing is requesting. **ST_RELOAD** spends one cycle refilling every counter from its weight and then takes *RELOAD→IDLE*. **ST_BUSY** holds the grant steady until the transfer-done strobe. It then takes *BUSY→IDLE* and stays in *BUSY→BUSY* while it waits.

Top module: `wrr_bus_arbiter`

## Requirements
- R1: While reset is active, and in the first cycle after it, `gnt` is all zero and `bus_busy` is low. The credit counters start empty, and the rotation pointer starts at master 0. So with every master requesting, the first grant after reset goes to master 0, and it arrives after a RELOAD cycle.
- R2: `gnt` has at most one bit set. `bus_busy` is high exactly when one bit of `gnt` is set. While busy, `gnt_idx` holds the binary index of that bit.
- R3: A grant is only issued to a master whose `req` bit was high, and whose weight field was nonzero, in the IDLE cycle where the decision was made. When no master requests, no grant appears. A master with weight 0 is never granted.
- R4: The search starts at the pointer and walks upward, wrapping modulo the number of masters. The first eligible master wins. After a grant, the pointer moves to the winner's index plus one, wrapping to 0 after the last master.
- R5: Each grant uses up one credit of the winning master. A master whose credit is zero is skipped, even when it is requesting.
- R6: When some master requests with a nonzero weight but no such master has credit, the arbiter spends exactly one RELOAD cycle loading every counter from its weight field. It then returns to IDLE without issuing a grant in that cycle.
- R7: Once issued, a grant stays unchanged until `xfer_done` is seen high in a BUSY cycle. The grant is removed on the following clock edge.
- R8: Suppose masters request continuously with weights w0..wn and each transfer completes at once. Then over the first full set of rounds, master i receives exactly k·wi grants for k rounds.
- R9: A decision made in IDLE shows on `gnt` after the next clock edge. `xfer_done` has no effect outside BUSY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_REQ | One request line per master |
| weight | input | N_REQ*W_W | Weight of master i in bits [i*W_W +: W_W] |
| xfer_done | input | 1 | Strobe: the granted byte transfer has finished |
| gnt | output | N_REQ | One-hot grant |
| gnt_idx | output | $clog2(N_REQ) | Index of the granted master |
| bus_busy | output | 1 | High while a grant is held |

## Verification
Two events can land in the same cycle. The first is a request being withdrawn in the very IDLE cycle in which that master would have won. The second is a master running out of credit at the same decision where others still hold credit, so the arbiter must skip it rather than reload. Requests are toggled pseudo-randomly on every cycle, and `xfer_done` arrives after random delays. This puts both coincidences into play many times. The verdict comes from comparing `gnt`, `gnt_idx` and `bus_busy` on every clock against a behavioural model that keeps its own credits and pointer. Directed phases add a check on the exact per-master grant counts, and a check that idle-time `xfer_done` strobes are ignored.

// File: rtl/wrr_pkg.sv
package wrr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RELOAD = 2'd1,
        ST_BUSY   = 2'd2
    } arb_state_e;

endpackage

// File: rtl/wrr_credit_bank.sv
module wrr_credit_bank #(
    parameter int N_REQ = 8,
    parameter int W_W   = 4,
    localparam int IW   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   dec,
    input  logic [IW-1:0]          dec_idx,
    input  logic [N_REQ*W_W-1:0]   weight,
    output logic [N_REQ-1:0]       has_credit
);

    for (genvar g = 0; g < N_REQ; g++) begin : g_slot
        logic [W_W-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (load) begin
                cnt <= weight[g*W_W +: W_W];
            end else if (dec && (dec_idx == IW'(g))) begin
                cnt <= cnt - 1'b1;
            end
        end

        assign has_credit[g] = |cnt;
    end

endmodule

// File: rtl/wrr_rr_picker.sv
module wrr_rr_picker #(
    parameter int N_REQ = 8,
    localparam int IW   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic [N_REQ-1:0] elig,
    input  logic [IW-1:0]    ptr,
    output logic             found,
    output logic [IW-1:0]    win
);

    function automatic logic [IW-1:0] rot(input logic [IW-1:0] base, input int off);
        int s;
        s = int'(base) + off;
        if (s >= N_REQ) s = s - N_REQ;
        return IW'(s);
    endfunction

    // walk from farthest to nearest so the nearest eligible slot wins
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = N_REQ - 1; k >= 0; k--) begin
            if (elig[rot(ptr, k)]) begin
                found = 1'b1;
                win   = rot(ptr, k);
            end
        end
    end

endmodule

// File: rtl/wrr_bus_arbiter.sv
module wrr_bus_arbiter
    import wrr_pkg::*;
#(
    parameter int N_REQ = 8,
    parameter int W_W   = 4,
    localparam int IW   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_REQ-1:0]       req,
    input  logic [N_REQ*W_W-1:0]   weight,
    input  logic                   xfer_done,
    output logic [N_REQ-1:0]       gnt,
    output logic [IW-1:0]          gnt_idx,
    output logic                   bus_busy
);

    localparam logic [IW-1:0]    LAST_IDX = IW'(N_REQ - 1);
    localparam logic [N_REQ-1:0] ONE_HOT0 = {{(N_REQ-1){1'b0}}, 1'b1};

    arb_state_e          state, state_nx;
    logic [IW-1:0]       ptr;
    logic [N_REQ-1:0]    w_nz;
    logic [N_REQ-1:0]    has_credit;
    logic [N_REQ-1:0]    weighted;
    logic [N_REQ-1:0]    elig;
    logic                found;
    logic [IW-1:0]       win;
    logic                load;
    logic                dec;

    for (genvar g = 0; g < N_REQ; g++) begin : g_wnz
        assign w_nz[g] = |weight[g*W_W +: W_W];
    end

    assign weighted = req & w_nz;
    assign elig     = weighted & has_credit;
    assign load     = (state == ST_RELOAD);
    assign dec      = (state == ST_IDLE) && found;

    wrr_credit_bank #(.N_REQ(N_REQ), .W_W(W_W)) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .dec        (dec),
        .dec_idx    (win),
        .weight     (weight),
        .has_credit (has_credit)
    );

    wrr_rr_picker #(.N_REQ(N_REQ)) u_pick (
        .elig  (elig),
        .ptr   (ptr),
        .found (found),
        .win   (win)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (found)          state_nx = ST_BUSY;
                else if (|weighted) state_nx = ST_RELOAD;
            end
            ST_RELOAD:              state_nx = ST_IDLE;
            ST_BUSY: begin
                if (xfer_done)      state_nx = ST_IDLE;
            end
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt     <= '0;
            gnt_idx <= '0;
            ptr     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (found) begin
                        gnt     <= ONE_HOT0 << win;
                        gnt_idx <= win;
                        ptr     <= (win == LAST_IDX) ? '0 : win + 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (xfer_done) gnt <= '0;
                end
                default: ;
            endcase
        end
    end

    assign bus_busy = (state == ST_BUSY);

endmodule

// File: rtl/wrr_bus_arbiter_chk.sv
module wrr_bus_arbiter_chk #(
    parameter int N_REQ = 8,
    parameter int W_W   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_REQ-1:0]     req,
    input logic [N_REQ*W_W-1:0] weight,
    input logic                 xfer_done,
    input logic [N_REQ-1:0]     gnt,
    input logic                 bus_busy
);

    logic [N_REQ-1:0] wnz;
    for (genvar g = 0; g < N_REQ; g++) begin : g_w
        assign wnz[g] = |weight[g*W_W +: W_W];
    end

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_busy_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy == (gnt != '0));

    p_requested_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> ((gnt & $past(req)) == gnt));

    p_weighted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> ((gnt & $past(wnz)) == gnt));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && !xfer_done) |=> $stable(gnt));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && xfer_done) |=> !bus_busy);

endmodule

bind wrr_bus_arbiter wrr_bus_arbiter_chk #(.N_REQ(N_REQ), .W_W(W_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .weight    (weight),
    .xfer_done (xfer_done),
    .gnt       (gnt),
    .bus_busy  (bus_busy)
);

// File: tb/wrr_bus_arbiter_tb.sv
`timescale 1ns/1ps
module wrr_bus_arbiter_tb;

    localparam int N  = 8;
    localparam int WW = 4;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic [N*WW-1:0] weight;
    logic            xfer_done = 1'b0;
    logic [N-1:0]    gnt;
    logic [IW-1:0]   gnt_idx;
    logic            bus_busy;

    int wt [N];
    int n_cmp  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) weight[i*WW +: WW] = WW'(wt[i]);
    end

    wrr_bus_arbiter #(.N_REQ(N), .W_W(WW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .weight(weight),
        .xfer_done(xfer_done), .gnt(gnt), .gnt_idx(gnt_idx), .bus_busy(bus_busy)
    );

    // behavioural reference: 0 idle, 1 reload, 2 busy
    int m_state = 0;
    int m_ptr   = 0;
    int m_win   = 0;
    int m_cred [N];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_ptr = 0; m_win = 0;
            for (int i = 0; i < N; i++) m_cred[i] = 0;
        end else begin
            case (m_state)
                0: begin
                    int pick;
                    bit any_w;
                    pick = -1; any_w = 0;
                    for (int k = 0; k < N; k++) begin
                        int j;
                        j = (m_ptr + k) % N;
                        if (req[j] && wt[j] != 0) begin
                            any_w = 1;
                            if (pick < 0 && m_cred[j] > 0) pick = j;
                        end
                    end
                    if (pick >= 0) begin
                        m_win = pick;
                        m_cred[pick] = m_cred[pick] - 1;
                        m_ptr = (pick + 1) % N;
                        m_state = 2;
                    end else if (any_w) begin
                        m_state = 1;
                    end
                end
                1: begin
                    for (int i = 0; i < N; i++) m_cred[i] = wt[i];
                    m_state = 0;
                end
                default: if (xfer_done) m_state = 0;
            endcase
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // waits for the falling edge and compares against the model
    task automatic tick();
        logic [N-1:0] eg;
        bit           eb;
        @(negedge clk);
        eb = (m_state == 2);
        eg = eb ? (N'(1) << m_win) : '0;
        check(gnt == eg, "R2,R4,R5,R6,R7 gnt vs model", int'(gnt), int'(eg));
        check(bus_busy == eb, "R7,R9 bus_busy vs model", int'(bus_busy), int'(eb));
        if (eb) check(int'(gnt_idx) == m_win, "R2 gnt_idx vs model", int'(gnt_idx), m_win);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        int cnt [N];
        int total;
        int first;
        int hits3;
        int busy_c;

        for (int i = 0; i < N; i++) wt[i] = (i < 4) ? i + 1 : 0;
        req = '0;
        repeat (4) @(negedge clk);
        check(gnt == '0, "R1 gnt in reset", int'(gnt), 0);
        check(bus_busy == 1'b0, "R1 busy in reset", int'(bus_busy), 0);
        rst_n = 1'b1;
        tick();
        check(gnt == '0, "R1 gnt after reset", int'(gnt), 0);

        // phase A: exact proportions, immediate completion
        for (int i = 0; i < N; i++) cnt[i] = 0;
        total = 0; first = -1;
        req = 8'h0F;
        for (int c = 0; c < 600 && total < 30; c++) begin
            tick();
            if (bus_busy) begin
                if (first < 0) first = int'(gnt_idx);
                cnt[gnt_idx]++;
                total++;
            end
            xfer_done = bus_busy;
        end
        check(first == 0, "R1 first grant from pointer 0", first, 0);
        for (int i = 0; i < 4; i++)
            check(cnt[i] == 3 * (i + 1), "R8 grant share over three rounds", cnt[i], 3 * (i + 1));
        check(total == 30, "R8 total grants", total, 30);
        req = '0;
        xfer_done = 1'b1;
        repeat (4) tick();
        xfer_done = 1'b0;

        // phase B: random requests and delays, master 3 weighted zero
        for (int i = 0; i < N; i++) wt[i] = (i * 3 + 1) % 5;
        hits3 = 0;
        for (int c = 0; c < 1500; c++) begin
            tick();
            if (bus_busy && gnt[3]) hits3++;
            req = N'($urandom);
            xfer_done = bus_busy && ($urandom % 3 == 0);
        end
        check(hits3 == 0, "R3 zero-weight master never granted", hits3, 0);

        // phase C: drain, then strobes with no requests
        req = '0;
        xfer_done = 1'b1;
        repeat (4) tick();
        busy_c = 0;
        for (int c = 0; c < 40; c++) begin
            tick();
            if (bus_busy) busy_c++;
            xfer_done = c[0];
        end
        check(busy_c == 0, "R3,R9 no grant without request", busy_c, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule